// File: doc/BRIEF.md
# Event Timer Global Registers and Main Counter

This block is the shared front of a multi-channel event timer. It owns the global register set: a read-only capabilities word, a general configuration register whose only live bit is the global counting enable, and a 32-bit main counter. The counter advances by one on every tick-enable strobe while counting is enabled and holds its value while counting is disabled. The counter value and the enable are sent to the per-channel comparators, which sit in separate blocks, as is the interrupt status logic.

Software reaches the registers through a simple valid/ready register port that carries an offset, a write flag, 64 bits of write data and the access size in bytes. Only naturally aligned 4-byte or 8-byte accesses are honoured. A 4-byte access whose offset has bit 2 set works on the upper half of the 64-bit register it falls in. Every read gets a response one cycle later, and writes get none. The port is always ready.

The tick strobe is expected at 2^24 per second, and the capabilities word reports that period in femtoseconds. The main counter can be rewritten at any time, and the new value applies in the next cycle whether or not counting is enabled.

Top module: `etmr_global_regs`

## Requirements
- R1: After a synchronous reset the enable output is 0, the counter output is 0, no response is pending, and reads of the configuration register (offset 0x10) and the counter (offset 0xF0) return 0.
- R2: An 8-byte read at offset 0x00 returns the constant capabilities word 0x038D7EA4_00000701: bits 63:32 hold the tick period in femtoseconds (10^15 / 2^24, truncated), bits 12:8 hold the channel count minus one (7), bit 13 (counter width flag) is 0, bits 7:0 hold the revision 1. Writes to offset 0x00 leave it unchanged.
- R3: In the configuration register at offset 0x10 only bit 0 (enable) can be written, and all other bits read 0. A 4-byte write at offset 0x14 leaves the enable unchanged, and a 4-byte read there returns 0.
- R4: While the enable is 1, each cycle with tick_en high adds one to the counter. While the enable is 0 the counter holds, and counting resumes from the held value once the enable is set again.
- R5: The counter wraps from 0xFFFFFFFF to 0x00000000 on a tick.
- R6: A legal write to the counter changes it in the next cycle, whether or not counting is enabled, and takes priority over a tick in the same cycle. An 8-byte write or a 4-byte write at 0xF0 loads bits 31:0 of the data. A 4-byte write at 0xF4 leaves the 32-bit counter unchanged.
- R7: The counter reads back zero-extended to 64 bits. A 4-byte read at offset+4 returns the upper half of the 64-bit register in bits 31:0, and a 4-byte read at the base offset returns the lower half. In both cases bits 63:32 of the read data are 0.
- R8: An access whose size is not 4 or 8 bytes, or whose offset is not a multiple of its size, changes no register, and a read of it returns 0.
- R9: req_ready is always 1. Every accepted read, legal or not, raises rsp_valid for exactly the next cycle with its data in rsp_rdata. A write or an idle cycle leaves rsp_valid low in the next cycle.
- R10: A read at any offset other than the three registers' 8-byte slots returns 0.
- R11: cnt_run always equals the enable bit as it reads back from the configuration register, and cnt_value always equals the counter as it reads back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset within the register window |
| req_size | input | 4 | Access size in bytes (4 or 8 honoured) |
| req_wdata | input | 64 | Write data, lower half used for 4-byte writes |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 64 | Read data |
| tick_en | input | 1 | Counter advance strobe |
| cnt_value | output | 32 | Main counter value to the comparators |
| cnt_run | output | 1 | Global counting enable to the comparators |

## Verification
Assertions watch every cycle for the counter's hold-when-idle, single-step, wrap and write-priority rules. They also check that an upper-half configuration write leaves the enable alone, that every read gets exactly one response and writes get none, and that illegal and unmapped reads return zero. The bench scenarios are needed for things a single-cycle property cannot show: the exact field values of the capabilities word, which half a 4-byte read returns, counting that resumes from a held value after the enable is cycled, the boundary at 0xFFFFFFFF, and a tick that coincides with a counter write.

// File: rtl/etmr_pkg.sv
package etmr_pkg;

    localparam int unsigned BUS_W          = 64;
    localparam int unsigned HALF_W         = 32;
    localparam int unsigned TIMER_COUNT    = 8;
    localparam int unsigned REVISION       = 1;
    localparam int unsigned TICK_RATE_LOG2 = 24;
    localparam logic [63:0] FS_PER_SECOND  = 64'd1000000000000000;

    // Register slot offsets (8-byte slots)
    localparam int unsigned OFS_CAPS  = 'h000;
    localparam int unsigned OFS_GCFG  = 'h010;
    localparam int unsigned OFS_COUNT = 'h0F0;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_CAPS  = 2'd1,
        SEL_GCFG  = 2'd2,
        SEL_COUNT = 2'd3
    } sel_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic legal;
        logic wide;
        logic upper;
        sel_e sel;
    } acc_t;

    // Constant capabilities word assembled from its fields
    function automatic logic [63:0] caps_word();
        logic [63:0] w;
        w        = (FS_PER_SECOND >> TICK_RATE_LOG2) << 32;
        w[13]    = 1'b0;
        w[12:8]  = 5'(TIMER_COUNT - 1);
        w[7:0]   = 8'(REVISION);
        return w;
    endfunction

    // Size is 4 or 8 bytes and offset is a multiple of it
    function automatic logic size_legal(input logic [3:0] sz, input logic [2:0] low);
        return ((sz == 4'd4) && (low[1:0] == 2'b00)) ||
               ((sz == 4'd8) && (low == 3'b000));
    endfunction

endpackage

// File: rtl/etmr_acc_dec.sv
module etmr_acc_dec
    import etmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_size,
    output acc_t              acc
);
    localparam int unsigned SLOT_W = ADDR_W - 3;
    localparam logic [SLOT_W-1:0] SLOT_CAPS  = SLOT_W'(OFS_CAPS  >> 3);
    localparam logic [SLOT_W-1:0] SLOT_GCFG  = SLOT_W'(OFS_GCFG  >> 3);
    localparam logic [SLOT_W-1:0] SLOT_COUNT = SLOT_W'(OFS_COUNT >> 3);

    logic [SLOT_W-1:0] slot;

    always_comb begin
        slot      = req_addr[ADDR_W-1:3];
        acc       = '0;
        acc.rd    = req_valid && !req_write;
        acc.wr    = req_valid &&  req_write;
        acc.legal = size_legal(req_size, req_addr[2:0]);
        acc.wide  = (req_size == 4'd8);
        acc.upper = (req_size == 4'd4) && req_addr[2];
        if (slot == SLOT_CAPS)
            acc.sel = SEL_CAPS;
        else if (slot == SLOT_GCFG)
            acc.sel = SEL_GCFG;
        else if (slot == SLOT_COUNT)
            acc.sel = SEL_COUNT;
        else
            acc.sel = SEL_NONE;
    end

endmodule

// File: rtl/etmr_gcfg_reg.sv
module etmr_gcfg_reg (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_wide,
    input  logic wr_upper,
    input  logic wr_bit0,
    output logic enable
);
    logic en_q;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else if (wr_en && (wr_wide || !wr_upper))
            en_q <= wr_bit0;
    end

    assign enable = en_q;

    // R3: an upper-half write leaves the enable alone
    p_upper_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_wide && wr_upper) |=> $stable(en_q));

    // R3: a lower-half or full write sets the enable from data bit 0
    p_bit0_loads_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_wide || !wr_upper)) |=> (en_q == $past(wr_bit0)));

endmodule

// File: rtl/etmr_main_cnt.sv
module etmr_main_cnt #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_value,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (wr_en)
            cnt_q <= wr_value;
        else if (run && tick)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

    // R4: no write and no enabled tick -> the counter holds
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !(run && tick)) |=> $stable(cnt_q));

    // R4: an enabled tick below the top value adds exactly one
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && run && tick && (cnt_q != CNT_MAX)) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R5: an enabled tick at the top value returns to zero
    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && run && tick && (cnt_q == CNT_MAX)) |=> (cnt_q == '0));

    // R6: a write wins over any tick in the same cycle
    p_write_wins_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cnt_q == $past(wr_value)));

endmodule

// File: rtl/etmr_rd_mux.sv
module etmr_rd_mux
    import etmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  acc_t             acc,
    input  logic [63:0]      caps,
    input  logic             gcfg_en,
    input  logic [CNT_W-1:0] cnt,
    output logic             rsp_valid,
    output logic [63:0]      rsp_rdata
);
    logic [63:0] slot_data;
    logic [63:0] rd_data;
    logic        vld_q;
    logic [63:0] data_q;

    always_comb begin
        unique case (acc.sel)
            SEL_CAPS:  slot_data = caps;
            SEL_GCFG:  slot_data = {63'd0, gcfg_en};
            SEL_COUNT: slot_data = BUS_W'(cnt);
            default:   slot_data = '0;
        endcase

        if (!acc.legal)
            rd_data = '0;
        else if (acc.wide)
            rd_data = slot_data;
        else if (acc.upper)
            rd_data = {32'd0, slot_data[63:32]};
        else
            rd_data = {32'd0, slot_data[31:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            data_q <= '0;
        end else begin
            vld_q <= acc.rd;
            if (acc.rd)
                data_q <= rd_data;
        end
    end

    assign rsp_valid = vld_q;
    assign rsp_rdata = data_q;

endmodule

// File: rtl/etmr_global_regs.sv
module etmr_global_regs
    import etmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_size,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    input  logic              tick_en,
    output logic [CNT_W-1:0]  cnt_value,
    output logic              cnt_run
);
    localparam logic [63:0] CAPS = caps_word();

    acc_t             acc;
    logic             gcfg_en;
    logic             gcfg_wr;
    logic             cnt_wr;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_wr_val;
    logic             unused_wdata;

    assign req_ready    = 1'b1;
    assign unused_wdata = ^req_wdata;

    etmr_acc_dec #(.ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .acc       (acc)
    );

    assign gcfg_wr = acc.wr && acc.legal && (acc.sel == SEL_GCFG);
    assign cnt_wr  = acc.wr && acc.legal && (acc.sel == SEL_COUNT);

    etmr_gcfg_reg u_gcfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (gcfg_wr),
        .wr_wide  (acc.wide),
        .wr_upper (acc.upper),
        .wr_bit0  (req_wdata[0]),
        .enable   (gcfg_en)
    );

    // Merge a write into the zero-extended counter image
    generate
        if (CNT_W > HALF_W) begin : g_wide_cnt
            always_comb begin
                if (acc.wide)
                    cnt_wr_val = req_wdata[CNT_W-1:0];
                else if (acc.upper)
                    cnt_wr_val = {req_wdata[CNT_W-HALF_W-1:0], cnt_q[HALF_W-1:0]};
                else
                    cnt_wr_val = {cnt_q[CNT_W-1:HALF_W], req_wdata[HALF_W-1:0]};
            end
        end else begin : g_half_cnt
            always_comb begin
                if (acc.upper)
                    cnt_wr_val = cnt_q;
                else
                    cnt_wr_val = req_wdata[CNT_W-1:0];
            end
        end
    endgenerate

    etmr_main_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (gcfg_en),
        .tick     (tick_en),
        .wr_en    (cnt_wr),
        .wr_value (cnt_wr_val),
        .cnt      (cnt_q)
    );

    etmr_rd_mux #(.CNT_W(CNT_W)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .caps      (CAPS),
        .gcfg_en   (gcfg_en),
        .cnt       (cnt_q),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign cnt_value = cnt_q;
    assign cnt_run   = gcfg_en;

    // R2: a full read of the capabilities slot returns the constant word
    p_caps_read_r2: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && acc.legal && acc.wide && (acc.sel == SEL_CAPS)) |=> (rsp_rdata == CAPS));

    // R8: an illegal read returns zero
    p_illegal_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && !acc.legal) |=> (rsp_rdata == 64'd0));

    // R8: an illegal write changes neither register
    p_illegal_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && !acc.legal && !tick_en) |=> ($stable(cnt_q) && $stable(gcfg_en)));

    // R9: each read is answered in the next cycle
    p_read_rsp_r9: assert property (@(posedge clk) disable iff (rst)
        acc.rd |=> rsp_valid);

    // R9: writes and idle cycles produce no response
    p_no_rsp_r9: assert property (@(posedge clk) disable iff (rst)
        !acc.rd |=> !rsp_valid);

    // R10: unmapped reads return zero
    p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && (acc.sel == SEL_NONE)) |=> (rsp_rdata == 64'd0));

endmodule

// File: tb/etmr_global_regs_tb.sv
`timescale 1ns/1ps
module etmr_global_regs_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [3:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        tick_en = 1'b0;
    logic [31:0] cnt_value;
    logic        cnt_run;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [63:0] exp_caps;
    logic [63:0] rd_val;
    logic        rd_vld;
    logic        wr_rsp;

    always #2 clk = ~clk;

    etmr_global_regs u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .tick_en   (tick_en),
        .cnt_value (cnt_value),
        .cnt_run   (cnt_run)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [3:0] s, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = s; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        wr_rsp = rsp_valid;
    endtask

    task automatic rd(input logic [9:0] a, input logic [3:0] s);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = s;
        @(negedge clk);
        req_valid = 1'b0;
        rd_val = rsp_rdata;
        rd_vld = rsp_valid;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 cnt_value", 64'(cnt_value), 64'd0);
        check("R1 cnt_run", 64'(cnt_run), 64'd0);
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        rd(10'h010, 4'd8); check("R1 config read", rd_val, 64'd0);
        rd(10'h0F0, 4'd8); check("R1 counter read", rd_val, 64'd0);
        check("R9 ready", 64'(req_ready), 64'd1);
    endtask

    task automatic t_caps();
        rd(10'h000, 4'd8); check("R2 caps full", rd_val, exp_caps);
        check("R2 caps revision", 64'(rd_val[7:0]), 64'd1);
        check("R2 caps channels", 64'(rd_val[12:8]), 64'd7);
        rd(10'h000, 4'd4); check("R7 caps lower half", rd_val, {32'd0, exp_caps[31:0]});
        rd(10'h004, 4'd4); check("R7 caps upper half", rd_val, {32'd0, exp_caps[63:32]});
        wr(10'h000, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(10'h000, 4'd8); check("R2 caps after write", rd_val, exp_caps);
    endtask

    task automatic t_config();
        wr(10'h010, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(10'h010, 4'd8); check("R3 only bit0 sticks", rd_val, 64'd1);
        check("R11 run follows config", 64'(cnt_run), 64'd1);
        wr(10'h014, 4'd4, 64'd0);
        rd(10'h010, 4'd8); check("R3 upper write ignored", rd_val, 64'd1);
        rd(10'h014, 4'd4); check("R3 upper read zero", rd_val, 64'd0);
        wr(10'h010, 4'd4, 64'd0);
        check("R3 lower write clears", 64'(cnt_run), 64'd0);
        check("R4 no count without ticks", 64'(cnt_value), 64'd0);
    endtask

    task automatic t_count();
        wr(10'h010, 4'd8, 64'd1);
        ticks(5);
        check("R4 five ticks", 64'(cnt_value), 64'd5);
        rd(10'h0F0, 4'd8); check("R7 counter zero-extended", rd_val, 64'd5);
        check("R11 value matches read", 64'(cnt_value), rd_val);
        wr(10'h010, 4'd8, 64'd0);
        ticks(3);
        check("R4 holds while disabled", 64'(cnt_value), 64'd5);
        wr(10'h010, 4'd8, 64'd1);
        ticks(2);
        check("R4 resumes from held value", 64'(cnt_value), 64'd7);
    endtask

    task automatic t_wrap();
        wr(10'h0F0, 4'd8, 64'hAAAA_AAAA_FFFF_FFFE);
        check("R6 full write loads low bits", 64'(cnt_value), 64'hFFFF_FFFE);
        rd(10'h0F4, 4'd4); check("R7 counter upper half", rd_val, 64'd0);
        rd(10'h0F0, 4'd4); check("R7 counter lower half", rd_val, 64'hFFFF_FFFE);
        ticks(3);
        check("R5 wrap through zero", 64'(cnt_value), 64'd1);
    endtask

    task automatic t_write();
        wr(10'h010, 4'd8, 64'd0);
        wr(10'h0F0, 4'd4, 64'h0000_0000_0000_1234);
        check("R6 write while disabled", 64'(cnt_value), 64'h1234);
        wr(10'h0F4, 4'd4, 64'h0000_0000_0000_DEAD);
        check("R6 upper write keeps counter", 64'(cnt_value), 64'h1234);
        wr(10'h010, 4'd8, 64'd1);
        @(negedge clk);
        tick_en = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 10'h0F0; req_size = 4'd8;
        req_wdata = 64'h50;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; tick_en = 1'b0;
        check("R6 write beats tick", 64'(cnt_value), 64'h50);
        ticks(1);
        check("R4 tick after write", 64'(cnt_value), 64'h51);
    endtask

    task automatic t_illegal();
        wr(10'h0F0, 4'd2, 64'h99);
        check("R8 size 2 write ignored", 64'(cnt_value), 64'h51);
        wr(10'h0F2, 4'd4, 64'h99);
        check("R8 misaligned 4 ignored", 64'(cnt_value), 64'h51);
        wr(10'h0F4, 4'd8, 64'h99);
        check("R8 misaligned 8 ignored", 64'(cnt_value), 64'h51);
        wr(10'h010, 4'd1, 64'd0);
        check("R8 size 1 config write ignored", 64'(cnt_run), 64'd1);
        rd(10'h000, 4'd2); check("R8 size 2 read zero", rd_val, 64'd0);
        rd(10'h004, 4'd8); check("R8 misaligned read zero", rd_val, 64'd0);
        rd(10'h011, 4'd1);
        check("R8 size 1 read zero", rd_val, 64'd0);
        check("R9 illegal read answered", 64'(rd_vld), 64'd1);
    endtask

    task automatic t_unmapped();
        rd(10'h020, 4'd8); check("R10 offset 0x20", rd_val, 64'd0);
        rd(10'h3F8, 4'd8); check("R10 offset 0x3F8", rd_val, 64'd0);
        rd(10'h0EC, 4'd4); check("R10 offset 0xEC", rd_val, 64'd0);
    endtask

    task automatic t_response();
        wr(10'h100, 4'd8, 64'd5);
        check("R9 write gives no response", 64'(wr_rsp), 64'd0);
        rd(10'h010, 4'd8);
        check("R9 read response valid", 64'(rd_vld), 64'd1);
        @(negedge clk);
        check("R9 response lasts one cycle", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        exp_caps = ((64'd1000000000000000 >> 24) << 32) | (64'd7 << 8) | 64'd1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_caps();
        t_config();
        t_count();
        t_wrap();
        t_write();
        t_illegal();
        t_unmapped();
        t_response();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule